// File: doc/BRIEF.md
# Programmable Colour-Bar Frame Generator

This block produces a synthetic video test frame as a byte stream that is organised into lines and frames. It is placed where a camera-link receiver would hand video to a CSI-2 style transmitter. Software programs the frame through a byte-wide write port. The settings are the data type code, the line length in bytes, the bar width in bytes, the active and total line counts, the line period in clock cycles, the back and front porch line counts, the bar pattern mode and block size, and an eight-entry colour table. Each table entry holds up to `BLK_MAX` bytes.

Each active line carries the same sequence of colour bars, so the picture shows vertical stripes only. Every byte belongs to a bar and to a byte slot within that bar's colour block. The block bytes repeat inside each bar, and the bar index wraps after eight bars. All timing is counted in payload bytes, lines and clock cycles; no pixel clock is involved. The frame is framed by frame-start, frame-end, line-start and line-end strobes. Two level signals mark the blanking lines and the sync lines. A sticky flag reports a line period that is too short for the programmed line length.

Register changes take effect only at a frame start, so a frame never mixes two settings. Clearing the enable bit stops the output on the next cycle. Setting it again starts a new frame from line 0.

Top module: `cbar_gen`

## Requirements
- R1: Write map (7-bit address, byte data): 0x00 bit 0 is enable; 0x01 holds the block size in bits 3:0 and the bar mode in bit 4; 0x02 is the data type; the 16-bit values are written as high then low byte at line length 0x03/0x04, bar width 0x05/0x06, active lines 0x07/0x08, total lines 0x09/0x0A and line period 0x0B/0x0C; back porch is 0x0D and front porch is 0x0E. After reset every register is zero and all outputs are low.
- R2: While running, `fs_o` pulses in cycle 0 of line 0. `fe_o` pulses in the last cycle of line max(total,1)-1. If enable is still set, the next frame's `fs_o` follows in the very next cycle.
- R3: A line lasts P = max(line period,1) cycles. An active line whose line length L exceeds P lasts L cycles instead.
- R4: Line n is a back-porch line for n < VBP, an active line for VBP <= n < VBP+ACT, and a front-porch line for the next VFP lines. All later lines are sync lines. While running, `blank_o` is high on every non-active line and `vsync_o` is high on the sync lines only.
- R5: On an active line, `valid_o` is high for cycles 0..L-1. `ls_o` marks cycle 0 and `le_o` marks cycle L-1. `dtype_o` shows the frame's data type while running and reads 0 otherwise.
- R6: Byte i of an active line, with W = max(bar width,1) and B the effective block size, is colour entry ((i/W) mod 8), byte slot ((i mod W) mod B). `data_o` is 0 when `valid_o` is low.
- R7: A block size of 0 acts as 1, and a block size above `BLK_MAX` acts as `BLK_MAX`. With bar mode 0, every byte uses colour entry 0 and keeps the same slot sequence.
- R8: Writes made during a frame do not change that frame's output. The new values apply from the next frame start.
- R9: `overrun_o` is set after the first cycle of an active line with L > P. It then stays high until reset, and the line is still emitted in full.
- R10: When enable is cleared, all outputs except `overrun_o` are low from the second clock edge onward. When enable is set again, `fs_o` appears in the cycle after the second edge.
- R11: Colour byte k of entry b is written at address 0x40 + 8*b + k. Writes with k >= `BLK_MAX` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Generator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 7 | Register write address |
| wr_data_i | input | 8 | Register write data |
| fs_o | output | 1 | Frame start strobe |
| fe_o | output | 1 | Frame end strobe |
| ls_o | output | 1 | Line start strobe, with first byte |
| le_o | output | 1 | Line end strobe, with last byte |
| valid_o | output | 1 | Payload byte valid |
| data_o | output | 8 | Payload byte |
| dtype_o | output | 8 | Data type code of the current frame |
| blank_o | output | 1 | Current line is not active |
| vsync_o | output | 1 | Current line is a sync line |
| overrun_o | output | 1 | Sticky flag: line period shorter than line length |

## Verification
The bench builds the block with its default `BLK_MAX` of 5. That is large enough to cover both the 3-byte and the 5-byte block layouts, and small enough that a block size of 9 exercises the clamp. Frames are programmed with a few lines of a few dozen bytes and bar widths of 0 to 4 bytes. These short frames bring the following cases within a few hundred cycles each: bar-index wrap past eight bars, bars that end mid-block, a zero total line count that gives back-to-back single-line frames, and an overrun line that stretches the frame. Mid-frame writes, disable and re-enable, and a reset during a run are all compared against the reference model on every cycle.

// File: rtl/cbar_pkg.sv
package cbar_pkg;
  parameter int unsigned CNT_W  = 16;  // counts are written as two bytes
  parameter int unsigned ADDR_W = 7;
  parameter int unsigned NBARS  = 8;
  parameter int unsigned BAR_W  = $clog2(NBARS);

  localparam logic [ADDR_W-1:0] A_CTRL  = 7'h00;
  localparam logic [ADDR_W-1:0] A_PAT   = 7'h01;
  localparam logic [ADDR_W-1:0] A_DT    = 7'h02;
  localparam logic [ADDR_W-1:0] A_LEN_H = 7'h03;
  localparam logic [ADDR_W-1:0] A_LEN_L = 7'h04;
  localparam logic [ADDR_W-1:0] A_BAR_H = 7'h05;
  localparam logic [ADDR_W-1:0] A_BAR_L = 7'h06;
  localparam logic [ADDR_W-1:0] A_ACT_H = 7'h07;
  localparam logic [ADDR_W-1:0] A_ACT_L = 7'h08;
  localparam logic [ADDR_W-1:0] A_TOT_H = 7'h09;
  localparam logic [ADDR_W-1:0] A_TOT_L = 7'h0A;
  localparam logic [ADDR_W-1:0] A_PD_H  = 7'h0B;
  localparam logic [ADDR_W-1:0] A_PD_L  = 7'h0C;
  localparam logic [ADDR_W-1:0] A_VBP   = 7'h0D;
  localparam logic [ADDR_W-1:0] A_VFP   = 7'h0E;
  localparam int unsigned       COL_BASE = 64;
  localparam int unsigned       COL_STRIDE = 8;

  typedef struct packed {
    logic             bars_on;
    logic [3:0]       blk;
    logic [7:0]       dtype;
    logic [CNT_W-1:0] line_bytes;
    logic [CNT_W-1:0] bar_bytes;
    logic [CNT_W-1:0] act_lines;
    logic [CNT_W-1:0] tot_lines;
    logic [CNT_W-1:0] line_pd;
    logic [7:0]       vbp;
    logic [7:0]       vfp;
  } cfg_t;
endpackage

// File: rtl/cbar_regs.sv
module cbar_regs
  import cbar_pkg::*;
#(
  parameter int unsigned BLK_MAX = 5
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                wr_en_i,
  input  logic [ADDR_W-1:0]                   wr_addr_i,
  input  logic [7:0]                          wr_data_i,
  input  logic                                load_i,
  output logic                                en_o,
  output cfg_t                                cfg_o,
  output logic [NBARS-1:0][BLK_MAX-1:0][7:0]  col_o
);
  cfg_t                               cfg_q;
  logic [NBARS-1:0][BLK_MAX-1:0][7:0] col_live;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o  <= 1'b0;
      cfg_q <= '0;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        A_CTRL:  en_o                   <= wr_data_i[0];
        A_PAT:   {cfg_q.bars_on, cfg_q.blk} <= wr_data_i[4:0];
        A_DT:    cfg_q.dtype            <= wr_data_i;
        A_LEN_H: cfg_q.line_bytes[15:8] <= wr_data_i;
        A_LEN_L: cfg_q.line_bytes[7:0]  <= wr_data_i;
        A_BAR_H: cfg_q.bar_bytes[15:8]  <= wr_data_i;
        A_BAR_L: cfg_q.bar_bytes[7:0]   <= wr_data_i;
        A_ACT_H: cfg_q.act_lines[15:8]  <= wr_data_i;
        A_ACT_L: cfg_q.act_lines[7:0]   <= wr_data_i;
        A_TOT_H: cfg_q.tot_lines[15:8]  <= wr_data_i;
        A_TOT_L: cfg_q.tot_lines[7:0]   <= wr_data_i;
        A_PD_H:  cfg_q.line_pd[15:8]    <= wr_data_i;
        A_PD_L:  cfg_q.line_pd[7:0]     <= wr_data_i;
        A_VBP:   cfg_q.vbp              <= wr_data_i;
        A_VFP:   cfg_q.vfp              <= wr_data_i;
        default: ;
      endcase
    end
  end

  for (genvar b = 0; b < NBARS; b++) begin : g_bar
    for (genvar k = 0; k < BLK_MAX; k++) begin : g_byte
      localparam logic [ADDR_W-1:0] ADDR = ADDR_W'(COL_BASE + b * COL_STRIDE + k);
      logic [7:0] byte_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                            byte_q <= '0;
        else if (wr_en_i && wr_addr_i == ADDR)  byte_q <= wr_data_i;
      end
      assign col_live[b][k] = byte_q;
    end
  end

  // frame-start snapshot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o <= '0;
      col_o <= '0;
    end else if (load_i) begin
      cfg_o <= cfg_q;
      col_o <= col_live;
    end
  end
endmodule

// File: rtl/cbar_timing.sv
module cbar_timing
  import cbar_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] line_bytes_i,
  input  logic [CNT_W-1:0] act_lines_i,
  input  logic [CNT_W-1:0] tot_lines_i,
  input  logic [CNT_W-1:0] line_pd_i,
  input  logic [7:0]       vbp_i,
  input  logic [7:0]       vfp_i,
  output logic             load_o,
  output logic             run_o,
  output logic             vld_o,
  output logic             last_o,
  output logic             fs_o,
  output logic             fe_o,
  output logic             blank_o,
  output logic             vsync_o,
  output logic             overrun_o
);
  localparam int unsigned LW = CNT_W + 1;

  logic [CNT_W-1:0] line_q, cyc_q, pd_eff, dur;
  logic [LW-1:0]    act_lo, act_hi, sync_lo, line_x;
  logic             is_act, long_line, eol, last_line, eof;

  assign pd_eff    = (line_pd_i == '0) ? CNT_W'(1) : line_pd_i;
  assign line_x    = {1'b0, line_q};
  assign act_lo    = LW'(vbp_i);
  assign act_hi    = act_lo + LW'(act_lines_i);
  assign sync_lo   = act_hi + LW'(vfp_i);
  assign is_act    = (line_x >= act_lo) && (line_x < act_hi);
  assign long_line = is_act && (line_bytes_i > pd_eff);
  assign dur       = long_line ? line_bytes_i : pd_eff;
  assign eol       = (cyc_q == dur - CNT_W'(1));
  assign last_line = (line_x + LW'(1)) >= {1'b0, tot_lines_i};
  assign eof       = run_o && eol && last_line;
  assign load_o    = en_i && (!run_o || eof);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o  <= 1'b0;
      line_q <= '0;
      cyc_q  <= '0;
    end else if (!en_i) begin
      run_o  <= 1'b0;
      line_q <= '0;
      cyc_q  <= '0;
    end else if (load_o) begin
      run_o  <= 1'b1;
      line_q <= '0;
      cyc_q  <= '0;
    end else if (eol) begin
      cyc_q  <= '0;
      line_q <= line_q + CNT_W'(1);
    end else begin
      cyc_q  <= cyc_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   overrun_o <= 1'b0;
    else if (run_o && long_line && cyc_q == '0)    overrun_o <= 1'b1;
  end

  assign vld_o   = run_o && is_act && (cyc_q < line_bytes_i);
  assign last_o  = vld_o && (cyc_q == line_bytes_i - CNT_W'(1));
  assign fs_o    = run_o && (line_q == '0) && (cyc_q == '0);
  assign fe_o    = eof;
  assign blank_o = run_o && !is_act;
  assign vsync_o = run_o && (line_x >= sync_lo);
endmodule

// File: rtl/cbar_bytes.sv
module cbar_bytes
  import cbar_pkg::*;
#(
  parameter int unsigned BLK_MAX = 5
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               vld_i,
  input  logic                               last_i,
  input  logic                               bars_on_i,
  input  logic [3:0]                         blk_i,
  input  logic [CNT_W-1:0]                   bar_bytes_i,
  input  logic [NBARS-1:0][BLK_MAX-1:0][7:0] col_i,
  output logic [7:0]                         data_o
);
  localparam int unsigned BK_W = (BLK_MAX > 1) ? $clog2(BLK_MAX) : 1;

  logic [CNT_W-1:0] bar_pos_q, bw_eff;
  logic [3:0]       blk_pos_q, bk_eff;
  logic [BAR_W-1:0] bar_idx_q, bar_sel;

  assign bw_eff = (bar_bytes_i == '0) ? CNT_W'(1) : bar_bytes_i;
  assign bk_eff = (blk_i == '0) ? 4'd1 : (blk_i > 4'(BLK_MAX)) ? 4'(BLK_MAX) : blk_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bar_pos_q <= '0;
      blk_pos_q <= '0;
      bar_idx_q <= '0;
    end else if (vld_i && !last_i) begin
      if (bar_pos_q == bw_eff - CNT_W'(1)) begin
        bar_pos_q <= '0;
        blk_pos_q <= '0;
        bar_idx_q <= bar_idx_q + BAR_W'(1);
      end else begin
        bar_pos_q <= bar_pos_q + CNT_W'(1);
        blk_pos_q <= (blk_pos_q == bk_eff - 4'd1) ? 4'd0 : blk_pos_q + 4'd1;
      end
    end else begin
      bar_pos_q <= '0;
      blk_pos_q <= '0;
      bar_idx_q <= '0;
    end
  end

  assign bar_sel = bars_on_i ? bar_idx_q : '0;
  assign data_o  = vld_i ? col_i[bar_sel][blk_pos_q[BK_W-1:0]] : 8'h00;
endmodule

// File: rtl/cbar_gen.sv
module cbar_gen
  import cbar_pkg::*;
#(
  parameter int unsigned BLK_MAX = 5
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [6:0]  wr_addr_i,
  input  logic [7:0]  wr_data_i,
  output logic        fs_o,
  output logic        fe_o,
  output logic        ls_o,
  output logic        le_o,
  output logic        valid_o,
  output logic [7:0]  data_o,
  output logic [7:0]  dtype_o,
  output logic        blank_o,
  output logic        vsync_o,
  output logic        overrun_o
);
  cfg_t                               cfg_sh;
  logic [NBARS-1:0][BLK_MAX-1:0][7:0] col_sh;
  logic                               gen_en, gen_run, gen_load, gen_last;

  cbar_regs #(.BLK_MAX(BLK_MAX)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .load_i (gen_load),
    .en_o   (gen_en),
    .cfg_o  (cfg_sh),
    .col_o  (col_sh)
  );

  cbar_timing u_timing (
    .clk_i, .rst_ni,
    .en_i         (gen_en),
    .line_bytes_i (cfg_sh.line_bytes),
    .act_lines_i  (cfg_sh.act_lines),
    .tot_lines_i  (cfg_sh.tot_lines),
    .line_pd_i    (cfg_sh.line_pd),
    .vbp_i        (cfg_sh.vbp),
    .vfp_i        (cfg_sh.vfp),
    .load_o       (gen_load),
    .run_o        (gen_run),
    .vld_o        (valid_o),
    .last_o       (gen_last),
    .fs_o, .fe_o, .blank_o, .vsync_o, .overrun_o
  );

  cbar_bytes #(.BLK_MAX(BLK_MAX)) u_bytes (
    .clk_i, .rst_ni,
    .vld_i       (valid_o),
    .last_i      (gen_last),
    .bars_on_i   (cfg_sh.bars_on),
    .blk_i       (cfg_sh.blk),
    .bar_bytes_i (cfg_sh.bar_bytes),
    .col_i       (col_sh),
    .data_o
  );

  assign ls_o    = valid_o && fs_line_first();
  assign le_o    = gen_last;
  assign dtype_o = gen_run ? cfg_sh.dtype : 8'h00;

  // first byte of a line: valid now, and no byte was valid-and-not-last before
  logic prev_mid_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_mid_q <= 1'b0;
    else         prev_mid_q <= valid_o && !gen_last;
  end

  function automatic logic fs_line_first();
    return !prev_mid_q;
  endfunction
endmodule

// File: rtl/cbar_gen_sva.sv
module cbar_gen_sva (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic       run_i,
  input logic       fs_o,
  input logic       fe_o,
  input logic       ls_o,
  input logic       le_o,
  input logic       valid_o,
  input logic [7:0] dtype_o,
  input logic       blank_o,
  input logic       vsync_o,
  input logic       overrun_o
);
  p_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fe_o && en_i) |=> fs_o);
  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |-> fs_o);
  p_blank_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_o |-> !valid_o);
  p_vsync_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsync_o |-> blank_o);
  p_strobe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ls_o || le_o) |-> valid_o);
  p_dtype_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !fs_o) |-> $stable(dtype_o));
  p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);
  p_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !(fs_o || fe_o || valid_o || blank_o || vsync_o));
endmodule

bind cbar_gen cbar_gen_sva u_sva (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (gen_en),
  .run_i     (gen_run),
  .fs_o      (fs_o),
  .fe_o      (fe_o),
  .ls_o      (ls_o),
  .le_o      (le_o),
  .valid_o   (valid_o),
  .dtype_o   (dtype_o),
  .blank_o   (blank_o),
  .vsync_o   (vsync_o),
  .overrun_o (overrun_o)
);

// File: tb/cbar_gen_tb.sv
module cbar_gen_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [6:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       fs_o, fe_o, ls_o, le_o, valid_o, blank_o, vsync_o, overrun_o;
  logic [7:0] data_o, dtype_o;

  cbar_gen u_dut (.*);

  always #10 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0, cyc_cnt = 0;
  bit cmp_on = 0, done = 0;
  string data_tag = "R6";

  // reference model: live and frame copies of settings, frame position
  int m_en, m_mode, m_blk, m_dt, m_L, m_W, m_act, m_tot, m_pd, m_vbp, m_vfp;
  int s_mode, s_blk, s_dt, s_L, s_W, s_act, s_tot, s_pd, s_vbp, s_vfp;
  int m_col [8][8];
  int s_col [8][8];
  int run, line, cyc, ov;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic int pde();
    return (s_pd == 0) ? 1 : s_pd;
  endfunction
  function automatic bit is_act();
    return line >= s_vbp && line < s_vbp + s_act;
  endfunction
  function automatic int line_dur();
    return (is_act() && s_L > pde()) ? s_L : pde();
  endfunction

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      {m_en, m_mode, m_blk, m_dt, m_L, m_W, m_act, m_tot, m_pd, m_vbp, m_vfp} = '0;
      {s_mode, s_blk, s_dt, s_L, s_W, s_act, s_tot, s_pd, s_vbp, s_vfp} = '0;
      for (int b = 0; b < 8; b++) for (int k = 0; k < 8; k++) begin m_col[b][k] = 0; s_col[b][k] = 0; end
      run = 0; line = 0; cyc = 0; ov = 0;
    end else begin
      bit eol, eof;
      eol = (cyc == line_dur() - 1);
      eof = run && eol && (line + 1 >= s_tot);
      if (run && is_act() && cyc == 0 && s_L > pde()) ov = 1;
      if (m_en == 0) begin run = 0; line = 0; cyc = 0; end
      else if (!run || eof) begin
        s_mode = m_mode; s_blk = m_blk; s_dt = m_dt; s_L = m_L; s_W = m_W;
        s_act = m_act; s_tot = m_tot; s_pd = m_pd; s_vbp = m_vbp; s_vfp = m_vfp;
        for (int b = 0; b < 8; b++) for (int k = 0; k < 8; k++) s_col[b][k] = m_col[b][k];
        run = 1; line = 0; cyc = 0;
      end else if (eol) begin cyc = 0; line++; end
      else cyc++;
      if (wr_en_i) begin
        case (wr_addr_i)
          7'h00: m_en = wr_data_i[0];
          7'h01: begin m_mode = wr_data_i[4]; m_blk = wr_data_i[3:0]; end
          7'h02: m_dt = wr_data_i;
          7'h03: m_L = (m_L & 255) | (wr_data_i << 8);
          7'h04: m_L = (m_L & 16'hFF00) | wr_data_i;
          7'h05: m_W = (m_W & 255) | (wr_data_i << 8);
          7'h06: m_W = (m_W & 16'hFF00) | wr_data_i;
          7'h07: m_act = (m_act & 255) | (wr_data_i << 8);
          7'h08: m_act = (m_act & 16'hFF00) | wr_data_i;
          7'h09: m_tot = (m_tot & 255) | (wr_data_i << 8);
          7'h0A: m_tot = (m_tot & 16'hFF00) | wr_data_i;
          7'h0B: m_pd = (m_pd & 255) | (wr_data_i << 8);
          7'h0C: m_pd = (m_pd & 16'hFF00) | wr_data_i;
          7'h0D: m_vbp = wr_data_i;
          7'h0E: m_vfp = wr_data_i;
          default: if (wr_addr_i[6] && wr_addr_i[2:0] < 5)
                     m_col[wr_addr_i[5:3]][wr_addr_i[2:0]] = wr_data_i;
        endcase
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk_i) begin
    if (rst_ni && cmp_on && !done) begin
      bit a, ev;
      int e_data, w, bsz, bar;
      a  = run && is_act();
      ev = a && cyc < s_L;
      w  = (s_W == 0) ? 1 : s_W;
      bsz = (s_blk == 0) ? 1 : (s_blk > 5) ? 5 : s_blk;
      bar = s_mode ? (cyc / w) % 8 : 0;
      e_data = ev ? s_col[bar][(cyc % w) % bsz] : 0;
      chk("R2 fs", fs_o, run && line == 0 && cyc == 0);
      chk("R2 fe", fe_o, run && cyc == line_dur() - 1 && line + 1 >= s_tot);
      chk("R4 blank", blank_o, run && !a);
      chk("R4 vsync", vsync_o, run && line >= s_vbp + s_act + s_vfp);
      chk("R5 valid", valid_o, ev);
      chk("R5 ls", ls_o, ev && cyc == 0);
      chk("R5 le", le_o, ev && cyc == s_L - 1);
      chk("R5 dtype", dtype_o, run ? s_dt : 0);
      chk(data_tag, data_o, e_data);
      chk("R9 overrun", overrun_o, ov);
    end
  end

  always @(posedge clk_i) begin
    cyc_cnt++;
    if (cyc_cnt == 150000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 7'(a); wr_data_i = 8'(d);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic set_cfg(input int pat, input int dt, input int L, input int W, input int act,
                         input int tot, input int pd, input int vbp, input int vfp);
    wr(1, pat); wr(2, dt);
    wr(3, L >> 8); wr(4, L & 255); wr(5, W >> 8); wr(6, W & 255);
    wr(7, act >> 8); wr(8, act & 255); wr(9, tot >> 8); wr(10, tot & 255);
    wr(11, pd >> 8); wr(12, pd & 255); wr(13, vbp); wr(14, vfp);
  endtask

  task automatic wait_fs();
    int k = 0;
    do begin @(negedge clk_i); k++; end while (!fs_o && k < 5000);
  endtask

  function automatic int frame_len(input int L, input int act, input int tot, input int pd, input int vbp);
    int p = (pd == 0) ? 1 : pd;
    int n = (tot == 0) ? 1 : tot;
    int s = 0;
    for (int i = 0; i < n; i++)
      s += (i >= vbp && i < vbp + act && L > p) ? L : p;
    return s;
  endfunction

  task automatic measure(input string tag, input int exp);
    int n = 0;
    wait_fs();
    do begin @(negedge clk_i); n++; end while (!fs_o && n < 5000);
    chk(tag, n, exp);
  endtask

  initial begin
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    cmp_on = 1;
    @(negedge clk_i);
    // R1: reset state
    chk("R1 idle", {fs_o, fe_o, ls_o, le_o, valid_o, blank_o, vsync_o, overrun_o}, 0);
    chk("R1 data", {data_o, dtype_o}, 0);

    // R11: colour table, including ignored slots
    for (int b = 0; b < 8; b++)
      for (int k = 0; k < 8; k++) wr(64 + b * 8 + k, (k < 5) ? b * 16 + k + 1 : 8'hEE);
    data_tag = "R11 data";
    set_cfg(8'h13, 8'h24, 20, 2, 3, 8, 24, 2, 1);
    wr(0, 1);
    measure("R3 frame length", frame_len(20, 3, 8, 24, 2));

    // R8: mid-frame change
    repeat (5) @(negedge clk_i);
    data_tag = "R6 data";
    set_cfg(8'h15, 8'h2B, 23, 3, 2, 6, 30, 1, 2);
    chk("R8 dtype held", dtype_o, 8'h24);
    wait_fs();
    chk("R8 dtype new", dtype_o, 8'h2B);
    measure("R3 frame length B", frame_len(23, 2, 6, 30, 1));

    // R7: solid mode, block clamp, zero bar width, zero total lines
    data_tag = "R7 data";
    set_cfg(8'h00, 8'h2A, 12, 0, 1, 0, 12, 0, 0);
    repeat (3) wait_fs();
    wr(1, 8'h09);
    repeat (3) wait_fs();
    wr(1, 8'h19); wr(5, 0); wr(6, 4);
    repeat (3) wait_fs();

    // R10: disable then re-enable
    repeat (5) @(negedge clk_i);
    wr(0, 0);
    @(negedge clk_i);
    chk("R10 off", {fs_o, valid_o, blank_o, vsync_o, dtype_o}, 0);
    repeat (3) @(negedge clk_i);
    wr(0, 1);
    @(negedge clk_i);
    chk("R10 restart", fs_o, 1);

    // R9: overrun
    data_tag = "R6 data";
    chk("R9 clear", overrun_o, 0);
    set_cfg(8'h13, 8'h24, 16, 4, 2, 4, 10, 1, 0);
    measure("R3 stretched frame", frame_len(16, 2, 4, 10, 1));
    chk("R9 set", overrun_o, 1);
    wait_fs();
    chk("R9 held", overrun_o, 1);

    // R1: reset during run
    repeat (7) @(negedge clk_i);
    #1 rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R1 reset clears", {fs_o, valid_o, blank_o, overrun_o, dtype_o}, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R1 stays idle", {fs_o, valid_o, blank_o}, 0);
    done = 1;
    report();
  end
endmodule